// File: doc/BRIEF.md
# DDR Read Return Burst Path

This block is the read side of a double-data-rate memory device model. It watches a registered command bus and recognises two commands: a mode-register load, which programs the burst length, the burst ordering and the read latency, and a READ, which starts a burst. Only a latency of three clocks is supported. A mode-register load with a reserved or unsupported field raises an error flag and leaves the previous settings in force.

For each accepted READ, the block walks the burst's column addresses in sequential or interleaved order. It presents two column addresses per clock to a storage array with a one-cycle synchronous read. It then returns the two data words of each clock as a rising-edge beat and a falling-edge beat, starting exactly three clocks after the READ edge. Two strobe-window flags frame the burst. The preamble flag is high for the clock before the first beat. The postamble flag is high for the clock after the last beat, and this clock stands for the half-clock trailing window. A READ that arrives while a burst is still being issued is dropped.

Top module: `ddr_rd_path`

## Requirements
- R1: Commands are decoded from {c_sel_n, c_row_n, c_col_n, c_wen_n}. 0000 is a mode-register load and 0101 is a READ. Any word with c_sel_n high, and every other code, has no effect.
- R2: A mode-register load with bank_in = 0 is legal when adr_in[2:0] is 001, 010 or 011 (burst length 2, 4 or 8), adr_in[6:4] is 011 (latency 3), adr_in[8:7] is 00 or 01, and adr_in[11:9] is 0. adr_in[3] then selects the order: 0 is sequential and 1 is interleaved. A legal load takes effect for the next READ and clears cfg_err.
- R3: A mode-register load with bank_in = 0 that breaks any condition of R2 sets cfg_err to 1 and keeps the previous burst length and order. cfg_err changes only in the clock after a mode-register load.
- R4: A mode-register load with a nonzero bank_in changes neither the burst settings nor cfg_err.
- R5: For a READ accepted at edge n with burst length BL, out_valid is high after edges n+3 through n+2+BL/2. Pair k (beats 2k and 2k+1) appears on out_rise and out_fall after edge n+3+k.
- R6: In sequential order, beat i reads the column whose low log2(BL) bits are (start offset + i) mod BL. The higher column bits stay unchanged.
- R7: In interleaved order, beat i reads the column whose low log2(BL) bits are (start offset XOR i). The higher column bits stay unchanged.
- R8: stb_pre is high for exactly the one clock after edge n+2, immediately before the first data clock.
- R9: stb_post is high for exactly the one clock after edge n+3+BL/2, immediately after the last data clock.
- R10: A READ registered at any edge from n+1 through n+1+BL/2 is ignored. A READ at edge n+2+BL/2 is accepted.
- R11: The burst start column is adr_in[9:0]. adr_in[11:10] do not affect the columns read. The READ's bank_in is forwarded on rd_bank.
- R12: After reset the burst length is 2, the order is sequential, cfg_err is 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| c_sel_n | input | 1 | Command select, active low |
| c_row_n | input | 1 | Command code bit (row strobe role) |
| c_col_n | input | 1 | Command code bit (column strobe role) |
| c_wen_n | input | 1 | Command code bit (write enable role) |
| bank_in | input | 2 | Bank of a READ; register select of a mode load |
| adr_in | input | 12 | Start column of a READ; opcode of a mode load |
| rd_en | output | 1 | Storage read request for the column pair below |
| rd_bank | output | 2 | Bank of the storage read |
| rd_col_even | output | 10 | Column of the rising-edge beat |
| rd_col_odd | output | 10 | Column of the falling-edge beat |
| rdata_even | input | 8 | Storage data for rd_col_even, one clock after rd_en |
| rdata_odd | input | 8 | Storage data for rd_col_odd, one clock after rd_en |
| out_rise | output | 8 | Beat transferred in the first half of the clock |
| out_fall | output | 8 | Beat transferred in the second half of the clock |
| out_valid | output | 1 | The current clock carries a beat pair |
| stb_pre | output | 1 | Strobe preamble window |
| stb_post | output | 1 | Strobe postamble window |
| cfg_err | output | 1 | The last base-register load was rejected |

## Verification
A READ at edge n puts its first beat pair out after edge n+3, the preamble after edge n+2 and the postamble after edge n+3+BL/2. A mode-register load shows its effect on cfg_err after the same edge that registers it. The bench drives each command half a clock before the edge that samples it, and it counts falling edges after that edge. It compares all three window flags on every clock of the burst window, and it checks the data beats on each clock that out_valid is due. Every rejected or ignored command is followed by a READ, so the settings that were kept can be seen through the burst length and the beat order.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  localparam int CAS_LAT    = 3;
  localparam int RAM_LAT    = 1;
  localparam int ADDR_LEAD  = CAS_LAT - RAM_LAT - 1;
  localparam int MAX_BL_LOG = 3;
  localparam int MAX_PAIRS  = 1 << (MAX_BL_LOG - 1);
  localparam logic [2:0] CL_CODE = 3'(CAS_LAT);

  typedef enum logic [1:0] {CMD_IDLE, CMD_MODE, CMD_READ, CMD_OTHER} cmd_e;

  typedef struct packed {
    logic [1:0] bl_log;
    logic       intlv;
  } burst_cfg_t;

  function automatic cmd_e cmd_decode(input logic sel_n, input logic row_n,
                                      input logic col_n, input logic wen_n);
    if (sel_n) return CMD_IDLE;
    case ({row_n, col_n, wen_n})
      3'b000:  return CMD_MODE;
      3'b101:  return CMD_READ;
      3'b111:  return CMD_IDLE;
      default: return CMD_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/ddr_rd_cmd_dec.sv
module ddr_rd_cmd_dec
  import ddr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c_sel_n,
  input  logic              c_row_n,
  input  logic              c_col_n,
  input  logic              c_wen_n,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [ADDR_W-1:0] adr_in,
  output logic              rd_go,
  output burst_cfg_t        cfg,
  output logic              cfg_err
);
  localparam int HI_W = ADDR_W - 9;

  cmd_e            cmd;
  logic [2:0]      f_bl;
  logic            f_bt;
  logic [2:0]      f_cl;
  logic [1:0]      f_om;
  logic [HI_W-1:0] f_hi;
  logic            legal;

  assign cmd   = cmd_decode(c_sel_n, c_row_n, c_col_n, c_wen_n);
  assign f_bl  = adr_in[2:0];
  assign f_bt  = adr_in[3];
  assign f_cl  = adr_in[6:4];
  assign f_om  = adr_in[8:7];
  assign f_hi  = adr_in[ADDR_W-1:9];
  assign rd_go = (cmd == CMD_READ);

  always_comb begin
    legal = (f_bl == 3'd1) || (f_bl == 3'd2) || (f_bl == 3'd3);
    legal = legal && (f_cl == CL_CODE) && !f_om[1] && (f_hi == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '{bl_log: 2'd1, intlv: 1'b0};
      cfg_err <= 1'b0;
    end else if (cmd == CMD_MODE && bank_in == '0) begin
      if (legal) begin
        cfg     <= '{bl_log: f_bl[1:0], intlv: f_bt};
        cfg_err <= 1'b0;
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq
  import ddr_rd_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic [COL_W-1:0]  col_in,
  input  logic [BANK_W-1:0] bank_in,
  input  burst_cfg_t        cfg,
  output logic              rd_en,
  output logic [BANK_W-1:0] rd_bank,
  output logic [COL_W-1:0]  rd_col_even,
  output logic [COL_W-1:0]  rd_col_odd,
  output logic              pre_tick
);
  localparam int PH_W = $clog2(ADDR_LEAD + MAX_PAIRS + 1);
  localparam int PW   = $clog2(MAX_PAIRS);
  localparam logic [PH_W-1:0] FIRST_PH = PH_W'(ADDR_LEAD - 1);
  localparam logic [PH_W-1:0] PRE_PH   = PH_W'(CAS_LAT - 2);

  logic              busy;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   rel;
  logic [PH_W-1:0]   n_pairs;
  logic [COL_W-1:0]  st_col;
  logic [BANK_W-1:0] st_bank;
  burst_cfg_t        st_cfg;
  logic              issue;
  logic [MAX_BL_LOG-1:0] beat0;

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] c,
                                                input burst_cfg_t bc,
                                                input logic [MAX_BL_LOG-1:0] i);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] off;
    logic [COL_W-1:0] nxt;
    mask = (COL_W'(1) << bc.bl_log) - COL_W'(1);
    off  = c & mask;
    nxt  = bc.intlv ? (off ^ COL_W'(i)) : (off + COL_W'(i));
    return (c & ~mask) | (nxt & mask);
  endfunction

  assign n_pairs  = PH_W'(1) << (st_cfg.bl_log - 2'd1);
  assign rel      = phase - FIRST_PH;
  assign issue    = busy && (rel < n_pairs);
  assign beat0    = {rel[PW-1:0], 1'b0};
  assign pre_tick = busy && (phase == PRE_PH);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      phase       <= '0;
      st_col      <= '0;
      st_bank     <= '0;
      st_cfg      <= '{bl_log: 2'd1, intlv: 1'b0};
      rd_en       <= 1'b0;
      rd_bank     <= '0;
      rd_col_even <= '0;
      rd_col_odd  <= '0;
    end else begin
      rd_en <= issue;
      if (issue) begin
        rd_bank     <= st_bank;
        rd_col_even <= beat_col(st_col, st_cfg, beat0);
        rd_col_odd  <= beat_col(st_col, st_cfg, beat0 | MAX_BL_LOG'(1));
      end
      if (!busy) begin
        if (rd_go) begin
          busy    <= 1'b1;
          phase   <= '0;
          st_col  <= col_in;
          st_bank <= bank_in;
          st_cfg  <= cfg;
        end
      end else if (rel == n_pairs) begin
        busy <= 1'b0;
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/ddr_rd_dq_out.sv
module ddr_rd_dq_out
  import ddr_rd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          pre_tick,
  input  logic [DW-1:0] rdata_even,
  input  logic [DW-1:0] rdata_odd,
  output logic [DW-1:0] out_rise,
  output logic [DW-1:0] out_fall,
  output logic          out_valid,
  output logic          stb_pre,
  output logic          stb_post
);
  logic [RAM_LAT-1:0] vld_sr;
  logic               data_vld;

  assign data_vld = vld_sr[RAM_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_sr    <= '0;
      out_rise  <= '0;
      out_fall  <= '0;
      out_valid <= 1'b0;
      stb_pre   <= 1'b0;
      stb_post  <= 1'b0;
    end else begin
      vld_sr[0] <= rd_en;
      for (int i = 1; i < RAM_LAT; i++) vld_sr[i] <= vld_sr[i-1];
      out_valid <= data_vld;
      out_rise  <= data_vld ? rdata_even : '0;
      out_fall  <= data_vld ? rdata_odd  : '0;
      stb_pre   <= pre_tick;
      stb_post  <= out_valid && !data_vld;
    end
  end
endmodule

// File: rtl/ddr_rd_path.sv
module ddr_rd_path
  import ddr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 10,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c_sel_n,
  input  logic              c_row_n,
  input  logic              c_col_n,
  input  logic              c_wen_n,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [ADDR_W-1:0] adr_in,
  output logic              rd_en,
  output logic [BANK_W-1:0] rd_bank,
  output logic [COL_W-1:0]  rd_col_even,
  output logic [COL_W-1:0]  rd_col_odd,
  input  logic [DW-1:0]     rdata_even,
  input  logic [DW-1:0]     rdata_odd,
  output logic [DW-1:0]     out_rise,
  output logic [DW-1:0]     out_fall,
  output logic              out_valid,
  output logic              stb_pre,
  output logic              stb_post,
  output logic              cfg_err
);
  logic       rd_go;
  logic       pre_tick;
  burst_cfg_t cfg;

  ddr_rd_cmd_dec #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst),
    .c_sel_n(c_sel_n), .c_row_n(c_row_n), .c_col_n(c_col_n), .c_wen_n(c_wen_n),
    .bank_in(bank_in), .adr_in(adr_in),
    .rd_go(rd_go), .cfg(cfg), .cfg_err(cfg_err)
  );

  ddr_rd_burst_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) u_seq (
    .clk(clk), .rst(rst), .rd_go(rd_go),
    .col_in(adr_in[COL_W-1:0]), .bank_in(bank_in), .cfg(cfg),
    .rd_en(rd_en), .rd_bank(rd_bank),
    .rd_col_even(rd_col_even), .rd_col_odd(rd_col_odd),
    .pre_tick(pre_tick)
  );

  ddr_rd_dq_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .rd_en(rd_en), .pre_tick(pre_tick),
    .rdata_even(rdata_even), .rdata_odd(rdata_odd),
    .out_rise(out_rise), .out_fall(out_fall), .out_valid(out_valid),
    .stb_pre(stb_pre), .stb_post(stb_post)
  );
endmodule

// File: rtl/ddr_rd_path_chk.sv
module ddr_rd_path_chk #(
  parameter int MAX_P = 4
) (
  input logic clk,
  input logic rst,
  input logic c_sel_n,
  input logic c_row_n,
  input logic c_col_n,
  input logic c_wen_n,
  input logic out_valid,
  input logic stb_pre,
  input logic stb_post,
  input logic cfg_err
);
  logic       is_read;
  logic       is_mode;
  logic [3:0] run;

  assign is_read = !c_sel_n && c_row_n && !c_col_n && c_wen_n;
  assign is_mode = !c_sel_n && !c_row_n && !c_col_n && !c_wen_n;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else     run <= out_valid ? run + 4'd1 : 4'd0;
  end

  AST_PRE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    stb_pre |-> $past(is_read, 3)); // R8
  AST_PRE_LEADS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(stb_pre)); // R8
  AST_POST_TRAILS_DATA: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> stb_post); // R9
  AST_WINDOW_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb_pre, out_valid, stb_post})); // R8
  AST_BURST_MAX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (run < 4'(MAX_P))); // R5
  AST_ERR_ON_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_err) |-> $past(is_mode)); // R3
endmodule

bind ddr_rd_path ddr_rd_path_chk #(.MAX_P(ddr_rd_pkg::MAX_PAIRS)) u_chk (
  .clk(clk), .rst(rst),
  .c_sel_n(c_sel_n), .c_row_n(c_row_n), .c_col_n(c_col_n), .c_wen_n(c_wen_n),
  .out_valid(out_valid), .stb_pre(stb_pre), .stb_post(stb_post),
  .cfg_err(cfg_err)
);

// File: tb/ddr_rd_path_bench.sv
module ddr_rd_path_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       c_sel_n = 1'b1, c_row_n = 1'b1, c_col_n = 1'b1, c_wen_n = 1'b1;
  logic [1:0] bank_in = '0;
  logic [11:0] adr_in = '0;
  logic       rd_en;
  logic [1:0] rd_bank;
  logic [9:0] rd_col_even, rd_col_odd;
  logic [7:0] rdata_even = '0, rdata_odd = '0;
  logic [7:0] out_rise, out_fall;
  logic       out_valid, stb_pre, stb_post, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_rd_path u_ddr_rd_path (
    .clk(clk), .rst(rst),
    .c_sel_n(c_sel_n), .c_row_n(c_row_n), .c_col_n(c_col_n), .c_wen_n(c_wen_n),
    .bank_in(bank_in), .adr_in(adr_in),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_col_even(rd_col_even), .rd_col_odd(rd_col_odd),
    .rdata_even(rdata_even), .rdata_odd(rdata_odd),
    .out_rise(out_rise), .out_fall(out_fall), .out_valid(out_valid),
    .stb_pre(stb_pre), .stb_post(stb_post), .cfg_err(cfg_err)
  );

  function automatic logic [7:0] fmem(input int b, input int c);
    return 8'((c * 5) + (b * 67) + (c >> 7));
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rdata_even <= fmem(int'(rd_bank), int'(rd_col_even));
      rdata_odd  <= fmem(int'(rd_bank), int'(rd_col_odd));
    end
  end

  function automatic int exp_col(input int col, input int blog, input int il, input int i);
    int bl, off, base;
    bl   = 1 << blog;
    off  = col % bl;
    base = col - off;
    return il != 0 ? base + (off ^ i) : base + ((off + i) % bl);
  endfunction

  function automatic logic [11:0] mk(input int bl, input int bt, input int cl,
                                     input int om, input int hi);
    return 12'((hi << 9) | (om << 7) | (cl << 4) | (bt << 3) | bl);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input logic s, input logic r, input logic c, input logic w,
                         input int b, input int a);
    c_sel_n = s; c_row_n = r; c_col_n = c; c_wen_n = w;
    bank_in = 2'(b); adr_in = 12'(a);
  endtask

  task automatic nop();
    set_cmd(1'b0, 1'b1, 1'b1, 1'b1, 0, 0);
  endtask

  task automatic mode_wr(input int b, input logic [11:0] op);
    @(negedge clk);
    set_cmd(1'b0, 1'b0, 1'b0, 1'b0, b, int'(op));
    @(negedge clk);
    nop();
  endtask

  // READ with full checking of timing windows (R5 R8 R9) and beat order (R6 R7 R11)
  task automatic run_read(input int b, input int adr, input int blog, input int il);
    int np, col;
    np  = 1 << (blog - 1);
    col = adr & 1023;
    @(negedge clk);
    set_cmd(1'b0, 1'b1, 1'b0, 1'b1, b, adr);
    for (int t = 0; t < np + 6; t++) begin
      @(negedge clk);
      if (t == 0) nop();
      check("R5 R8 R9 window flags", int'({stb_pre, out_valid, stb_post}),
            int'({(t == 2), (t >= 3 && t < 3 + np), (t == 3 + np)}));
      if (t >= 3 && t < 3 + np) begin
        check(il != 0 ? "R7 R11 interleaved beats" : "R6 R11 sequential beats",
              int'({out_rise, out_fall}),
              int'({fmem(b, exp_col(col, blog, il, 2*(t-3))),
                    fmem(b, exp_col(col, blog, il, 2*(t-3)+1))}));
      end
    end
  endtask

  // Two READs d edges apart; count data clocks (R10)
  task automatic two_reads(input int d, input int expv);
    int cnt;
    cnt = 0;
    @(negedge clk);
    set_cmd(1'b0, 1'b1, 1'b0, 1'b1, 0, 0);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (t == d - 1) set_cmd(1'b0, 1'b1, 1'b0, 1'b1, 1, 32);
      else nop();
      if (out_valid) cnt++;
    end
    check("R10 data clocks for read spacing", cnt, expv);
  endtask

  task automatic quiet_window(input string req, input logic s, input logic r,
                              input logic c, input logic w);
    int cnt;
    cnt = 0;
    @(negedge clk);
    set_cmd(s, r, c, w, 0, int'(mk(3, 1, 3, 0, 0)));
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      nop();
      if (out_valid || stb_pre || stb_post || rd_en) cnt++;
    end
    check(req, cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    nop();
    repeat (4) @(negedge clk);
    // R12: reset state
    check("R12 outputs in reset", int'({out_valid, stb_pre, stb_post, rd_en, cfg_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 outputs after reset", int'({out_valid, stb_pre, stb_post, rd_en, cfg_err}), 0);
    // R12: default burst is 2, sequential
    run_read(2, 5, 1, 0);

    // R2 R6 R7 R11: sweep all legal lengths, both orders, all start offsets
    for (int blog = 1; blog <= 3; blog++) begin
      for (int il = 0; il < 2; il++) begin
        mode_wr(0, mk(blog, il, 3, il, 0));
        check("R2 legal load clears error", int'(cfg_err), 0);
        for (int off = 0; off < 8; off++) begin
          run_read(off % 4, (off << 10) | (8 * (blog * 5 + il * 3) + off), blog, il);
        end
      end
    end

    // R3: reserved codes are rejected, settings kept (BL8 interleaved)
    mode_wr(0, mk(3, 1, 3, 0, 0));
    mode_wr(0, mk(0, 0, 3, 0, 0));
    check("R3 reserved length 000", int'(cfg_err), 1);
    run_read(1, 3, 3, 1);
    mode_wr(0, mk(4, 0, 3, 0, 0));
    check("R3 reserved length 100", int'(cfg_err), 1);
    mode_wr(0, mk(7, 0, 3, 0, 0));
    check("R3 reserved length 111", int'(cfg_err), 1);
    run_read(2, 6, 3, 1);
    mode_wr(0, mk(1, 0, 2, 0, 0));
    check("R3 reserved latency 010", int'(cfg_err), 1);
    mode_wr(0, mk(1, 0, 3, 2, 0));
    check("R3 reserved operating mode 10", int'(cfg_err), 1);
    mode_wr(0, mk(1, 0, 3, 0, 1));
    check("R3 nonzero high bits", int'(cfg_err), 1);
    run_read(3, 13, 3, 1);
    mode_wr(0, mk(2, 0, 3, 1, 0));
    check("R2 legal load after reject clears error", int'(cfg_err), 0);
    run_read(0, 7, 2, 0);

    // R4: extended-register loads ignored
    mode_wr(0, mk(5, 0, 3, 0, 0));
    check("R3 error set before extended load", int'(cfg_err), 1);
    mode_wr(1, mk(1, 1, 3, 0, 0));
    check("R4 bank 1 load leaves error", int'(cfg_err), 1);
    mode_wr(2, mk(3, 0, 3, 0, 0));
    check("R4 bank 2 load leaves error", int'(cfg_err), 1);
    run_read(1, 9, 2, 0);

    // R1: deselected and other codes have no effect
    quiet_window("R1 deselected READ ignored", 1'b1, 1'b1, 1'b0, 1'b1);
    quiet_window("R1 other command ignored", 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    set_cmd(1'b1, 1'b0, 1'b0, 1'b0, 0, int'(mk(3, 1, 3, 0, 0)));
    @(negedge clk);
    nop();
    check("R1 deselected load leaves error", int'(cfg_err), 1);
    run_read(0, 10, 2, 0);

    // R10: overlapping READs (BL8: 4 data clocks per burst)
    mode_wr(0, mk(3, 0, 3, 0, 0));
    two_reads(1, 4);
    two_reads(5, 4);
    two_reads(6, 8);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule